// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block connects two parallel buses, A and B, through two independent storage paths: one carries A toward B and the other carries B toward A. Each path has a single storage element. Its latch-enable and bus-clock inputs put it into one of three modes. With the latch enable high it is transparent. With the latch enable low it holds its value, unless the bus clock has a rising edge, in which case it captures. Each path drives its destination bus only while that path's output enable is asserted. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs from one system clock with a synchronous, active-high reset. Every control and data input is sampled on the rising system-clock edge. The bus clocks are treated as ordinary inputs whose rising edges are detected against their value at the previous sample. Each bus is presented as separate data-in, data-out and output-enable signals, so an enclosing level can build the tri-state pad. A per-bit keeper on each input bus stands in for bus hold. While the source marks a bus as undriven, the keeper supplies the last value that was driven onto that bus.

Top module: `bxcv_top`

## Requirements
- R1: Data passes through without inversion on all WIDTH bits (default 18), and every bit keeps its position. Each data output is the stored value of its path.
- R2: While `ab_le` is high at a clock edge, the A-to-B store takes the effective A value, and `b_out` shows it after that edge.
- R3: While `ab_le` is low and `ab_cp` shows no rising edge, the A-to-B store keeps its value whatever bus A does. When `ab_le` falls, the store keeps the value taken at the last edge where `ab_le` was high.
- R4: While `ab_le` is low, a clock edge at which `ab_cp` is sampled 1 after having been 0 at the previous edge captures the effective A value. A falling `ab_cp` captures nothing.
- R5: `ab_oe` is active high. `b_oe` equals the value of `ab_oe` sampled at the previous clock edge.
- R6: The B-to-A store follows the rules of R2 to R4, using `ba_le`, `ba_cp` and the effective B value, and drives `a_out`.
- R7: `ba_oe_n` is active low. `a_oe` equals the inverse of `ba_oe_n` sampled at the previous clock edge.
- R8: While a bus's `*_in_drv` is 1, that bus's keeper takes `*_in` at every edge. While `*_in_drv` is 0, the path uses the keeper's value instead of `*_in`.
- R9: After a clock edge with `rst` high, both stores, both keepers, `a_oe` and `b_oe` are 0. No bus-clock edge is counted across the reset.
- R10: The two paths share no state. With both directions enabled, each bus output carries only its own path's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Value seen on bus A |
| a_in_drv | input | 1 | 1 when something other than this block drives bus A |
| a_out | output | WIDTH | B-to-A stored value driven toward bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | WIDTH | Value seen on bus B |
| b_in_drv | input | 1 | 1 when something other than this block drives bus B |
| b_out | output | WIDTH | A-to-B stored value driven toward bus B |
| b_oe | output | 1 | Bus B output enable |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_cp | input | 1 | A-to-B bus clock |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable (high = transparent) |
| ba_cp | input | 1 | B-to-A bus clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench builds the block at its default WIDTH of 18. At that width the patterns 2AAAA, 15555 and 3FFFF reach every bit, including the top bit (bit 17), so any inversion or bit swap shows up directly. Because each path is a separate instance with its own polarity parameter, the bench drives the two directions to different values and mode settings at the same time. This checks that neither store nor enable leaks into the other path.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;
  typedef enum logic [1:0] {
    XM_HOLD = 2'd0,
    XM_FLOW = 2'd1,
    XM_EDGE = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/bxcv_keeper.sv
module bxcv_keeper #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             drv,
  output logic [WIDTH-1:0] eff
);
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)
      hold_q <= '0;
    else if (drv)
      hold_q <= din;
  end

  assign eff = drv ? din : hold_q;

  AST_KEEP_LAST: assert property (@(posedge clk) disable iff (rst)
    (!drv && $past(drv) && !$past(rst)) |-> eff == $past(din)); // R8
endmodule

// File: rtl/bxcv_path.sv
module bxcv_path
  import bxcv_pkg::*;
#(
  parameter int WIDTH  = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  input  logic             le,
  input  logic             cp,
  input  logic             oe_raw,
  output logic [WIDTH-1:0] q,
  output logic             oe
);
  logic             cp_q;
  logic             oe_act;
  logic             oe_q;
  logic [WIDTH-1:0] store_q;
  xfer_mode_e       mode;

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe_act = ~oe_raw;
    end else begin : g_oe_high
      assign oe_act = oe_raw;
    end
  endgenerate

  always_comb begin
    if (le)
      mode = XM_FLOW;
    else if (cp && !cp_q)
      mode = XM_EDGE;
    else
      mode = XM_HOLD;
  end

  always_ff @(posedge clk) begin
    cp_q <= cp;
    if (rst) begin
      store_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= oe_act;
      if (mode != XM_HOLD)
        store_q <= d;
    end
  end

  assign q  = store_q;
  assign oe = oe_q;

  AST_FLOW_TAKES_D: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(d)); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!le && !$rose(cp)) |=> $stable(q)); // R3
  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!le && $rose(cp)) |=> q == $past(d)); // R4
endmodule

// File: rtl/bxcv_top.sv
module bxcv_top #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_in_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_in_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_le,
  input  logic             ab_cp,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_cp,
  input  logic             ba_oe_n
);
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;

  bxcv_keeper #(.WIDTH(WIDTH)) u_keep_a (
    .clk(clk), .rst(rst), .din(a_in), .drv(a_in_drv), .eff(a_eff));
  bxcv_keeper #(.WIDTH(WIDTH)) u_keep_b (
    .clk(clk), .rst(rst), .din(b_in), .drv(b_in_drv), .eff(b_eff));

  bxcv_path #(.WIDTH(WIDTH), .OE_LOW(1'b0)) u_ab (
    .clk(clk), .rst(rst), .d(a_eff), .le(ab_le), .cp(ab_cp),
    .oe_raw(ab_oe), .q(b_out), .oe(b_oe));
  bxcv_path #(.WIDTH(WIDTH), .OE_LOW(1'b1)) u_ba (
    .clk(clk), .rst(rst), .d(b_eff), .le(ba_le), .cp(ba_cp),
    .oe_raw(ba_oe_n), .q(a_out), .oe(a_oe));

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R9
  AST_OE_AB_POL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b_oe == $past(ab_oe)); // R5
  AST_OE_BA_POL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_oe == !$past(ba_oe_n)); // R7
  AST_NO_CROSSTALK: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !$rose(ba_cp)) |=> $stable(a_out)); // R10
endmodule

// File: tb/test_bxcv_top.sv
module test_bxcv_top;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_in_drv, b_in_drv, a_oe, b_oe;
  logic         ab_le, ab_cp, ab_oe, ba_le, ba_cp, ba_oe_n;
  int           errs  = 0;
  int           total = 0;

  always #5 clk = ~clk;

  bxcv_top #(.WIDTH(W)) i_bxcv_top (
    .clk(clk), .rst(rst), .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_in_drv(b_in_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_cp(ab_cp), .ab_oe(ab_oe), .ba_le(ba_le),
    .ba_cp(ba_cp), .ba_oe_n(ba_oe_n));

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_at_negedge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    drive_at_negedge();
    rst = 1'b1; a_in = 18'h3FFFF; b_in = 18'h3FFFF; a_in_drv = 1'b1; b_in_drv = 1'b1;
    ab_le = 1'b1; ab_cp = 1'b0; ab_oe = 1'b1; ba_le = 1'b1; ba_cp = 1'b0; ba_oe_n = 1'b0;
    step(); step();
    check("R9 b_out", b_out, '0);
    check("R9 a_out", a_out, '0);
    check("R9 b_oe", {17'b0, b_oe}, '0);
    check("R9 a_oe", {17'b0, a_oe}, '0);
    drive_at_negedge();
    rst = 1'b0; ab_le = 1'b0; ba_le = 1'b0; ab_oe = 1'b0; ba_oe_n = 1'b1;
    step();
  endtask

  task automatic t_transparent();
    drive_at_negedge(); ab_le = 1'b1; a_in = 18'h2AAAA;
    step(); check("R2 follow 2AAAA", b_out, 18'h2AAAA);
    drive_at_negedge(); a_in = 18'h15555;
    step(); check("R1 no inversion 15555", b_out, 18'h15555);
    drive_at_negedge(); a_in = 18'h20001;
    step(); check("R1 edge bits", b_out, 18'h20001);
  endtask

  task automatic t_latched();
    drive_at_negedge(); a_in = 18'h0F0F0; ab_le = 1'b1;
    step();
    drive_at_negedge(); ab_le = 1'b0; a_in = 18'h30303;
    step(); check("R3 held on le fall", b_out, 18'h0F0F0);
    drive_at_negedge(); a_in = 18'h01234;
    step(); step(); check("R3 held with cp steady", b_out, 18'h0F0F0);
  endtask

  task automatic t_clocked();
    drive_at_negedge(); ab_le = 1'b0; ab_cp = 1'b0; a_in = 18'h11111;
    step();
    drive_at_negedge(); ab_cp = 1'b1;
    step(); check("R4 rising capture", b_out, 18'h11111);
    drive_at_negedge(); a_in = 18'h22222;
    step(); check("R4 high no capture", b_out, 18'h11111);
    drive_at_negedge(); ab_cp = 1'b0;
    step(); check("R4 falling no capture", b_out, 18'h11111);
    drive_at_negedge(); ab_cp = 1'b1;
    step(); check("R4 second rising", b_out, 18'h22222);
    drive_at_negedge(); ab_cp = 1'b0;
    step();
  endtask

  task automatic t_oe();
    drive_at_negedge(); ab_oe = 1'b1;
    step(); check("R5 ab_oe high drives", {17'b0, b_oe}, 18'h1);
    drive_at_negedge(); ab_oe = 1'b0;
    step(); check("R5 ab_oe low hi-z", {17'b0, b_oe}, 18'h0);
    drive_at_negedge(); ba_oe_n = 1'b0;
    step(); check("R7 ba_oe_n low drives", {17'b0, a_oe}, 18'h1);
    drive_at_negedge(); ba_oe_n = 1'b1;
    step(); check("R7 ba_oe_n high hi-z", {17'b0, a_oe}, 18'h0);
  endtask

  task automatic t_ba();
    drive_at_negedge(); ba_le = 1'b1; b_in = 18'h3C3C3;
    step(); check("R6 transparent", a_out, 18'h3C3C3);
    drive_at_negedge(); ba_le = 1'b0; ba_cp = 1'b0; b_in = 18'h00FFF;
    step(); check("R6 latched", a_out, 18'h3C3C3);
    drive_at_negedge(); ba_cp = 1'b1;
    step(); check("R6 clocked", a_out, 18'h00FFF);
    drive_at_negedge(); ba_cp = 1'b0;
    step();
  endtask

  task automatic t_keeper();
    drive_at_negedge(); a_in_drv = 1'b1; a_in = 18'h2468A; ab_le = 1'b0;
    step();
    drive_at_negedge(); a_in_drv = 1'b0; a_in = 18'h1DDDD; ab_le = 1'b1;
    step(); check("R8 keeper value used", b_out, 18'h2468A);
    drive_at_negedge(); a_in = 18'h0BEEF;
    step(); check("R8 keeper stays", b_out, 18'h2468A);
    drive_at_negedge(); a_in_drv = 1'b1;
    step(); check("R8 driven again", b_out, 18'h0BEEF);
    drive_at_negedge(); ab_le = 1'b0;
    step();
  endtask

  task automatic t_both();
    drive_at_negedge();
    ab_le = 1'b1; ba_le = 1'b1; ab_oe = 1'b1; ba_oe_n = 1'b0;
    a_in = 18'h12345; b_in = 18'h2BCDE; a_in_drv = 1'b1; b_in_drv = 1'b1;
    step(); step();
    check("R10 b_out own", b_out, 18'h12345);
    check("R10 a_out own", a_out, 18'h2BCDE);
    check("R10 both oe", {16'b0, a_oe, b_oe}, 18'h3);
    drive_at_negedge(); ba_le = 1'b0; a_in = 18'h3FFFF; b_in = 18'h00000;
    step();
    check("R10 ab moves", b_out, 18'h3FFFF);
    check("R10 ba unaffected", a_out, 18'h2BCDE);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_latched();
    t_clocked();
    t_oe();
    t_ba();
    t_keeper();
    t_both();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule